// File: doc/BRIEF.md
# Rectangle Raster-Op Copy Engine

This block moves a rectangle of 8-bit pixels within a pixel memory. For each pixel it reads an optional source pixel and the destination pixel. It combines the two with one of sixteen two-operand boolean operations and writes the result back to the destination address. Software programs the start addresses, row pitches, rectangle size, operation code, a fixed colour and the traversal direction through a small register write port. It then launches the job with a start bit, and watches `busy` and the one-cycle `done` pulse.

The memory side is a request/grant channel that carries one access at a time. The engine raises `mem_req` with address, direction and write data. The memory applies back-pressure by holding `mem_gnt` low. While the grant is low, every request field must stay unchanged. A read is complete on the edge where `mem_req` and `mem_gnt` are both high, and its data is on `mem_rdata` during the following cycle. Per-axis reverse walking lets a copy between overlapping rectangles finish without reading pixels it has already overwritten.

Top module: `rop_blit_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low, and stay low until a start is accepted.
- R2: Register writes (`reg_we` high) use these addresses: 0 source start (22 bits), 1 destination start (22 bits), 2 source pitch (12 bits), 3 destination pitch (12 bits), 4 width minus one (12 bits), 5 height minus one (12 bits), 6 mode, 7 fixed colour (bits 7:0), 8 control. Writing control with bit 0 set while idle starts a job, and `busy` is high in the next cycle. Writes to any register while `busy` is high are ignored.
- R3: The engine writes exactly (width+1)×(height+1) destination pixels.
- R4: Mode bits 3:0 select the result from S and D: 0→0, 1→S&D, 2→S&~D, 3→S, 4→~S&D, 5→D, 6→S^D, 7→S|D, 8→~(S|D), 9→~(S^D), A→~D, B→S|~D, C→~S, D→~S|D, E→~(S&D), F→all ones.
- R5: Mode bit 6 selects S. When the bit is 1, S is the source pixel. When it is 0, S is the fixed colour and no source reads are issued.
- R6: Mode bit 4 clear walks each row with addresses rising by one. When set, the addresses fall by one. The start address is the first pixel visited.
- R7: Mode bit 5 clear moves to the next row by adding the pitch to the row start. When set, it subtracts the pitch. Rows are visited in that order.
- R8: Each pixel is processed as: source read (if used), destination read, write of the result to that destination address. No access for the next pixel is issued before the write is granted.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values. Read data is taken from `mem_rdata` in the cycle after the granted read.
- R10: In the cycle after the final write is granted, `busy` is low and `done` is high for exactly one cycle.
- R11: A start written while `busy` is high is ignored. The running job completes unchanged, with a single `done` pulse.
- R12: An overlapping copy (operation 3) with direction bits chosen against the overlap leaves the destination equal to the source contents as they were before the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 22 | Register write data |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request (valid) |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 22 | Pixel address |
| mem_wdata | output | 8 | Pixel write data |
| mem_gnt | input | 1 | Memory accepts the request (ready) |
| mem_rdata | input | 8 | Read data, valid the cycle after a granted read |

## Verification
`busy` is due in the cycle after the start write. `done` is due exactly one cycle after the edge that grants the last write. The bench logs the cycle number of every granted access and compares the cycle of the `done` pulse against it. A pseudo-random grant pattern moves every result by a variable number of cycles. For that reason, memory contents, write order and access counts are compared only after `done` is seen. The bench never relies on a fixed latency for them. Outputs are sampled on falling edges, and the bench memory answers reads on the rising edge after the grant, as R9 states.

// File: rtl/rop_blit_pkg.sv
package rop_blit_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_SRC_START = 4'd0;
  localparam logic [REG_AW-1:0] RA_DST_START = 4'd1;
  localparam logic [REG_AW-1:0] RA_SRC_PITCH = 4'd2;
  localparam logic [REG_AW-1:0] RA_DST_PITCH = 4'd3;
  localparam logic [REG_AW-1:0] RA_WIDTH     = 4'd4;
  localparam logic [REG_AW-1:0] RA_HEIGHT    = 4'd5;
  localparam logic [REG_AW-1:0] RA_MODE      = 4'd6;
  localparam logic [REG_AW-1:0] RA_COLOUR    = 4'd7;
  localparam logic [REG_AW-1:0] RA_CTRL      = 4'd8;

  // mode register bit positions
  localparam int MB_XREV = 4;
  localparam int MB_YREV = 5;
  localparam int MB_SRC  = 6;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_SRC_REQ,
    WK_SRC_CAP,
    WK_DST_REQ,
    WK_DST_CAP,
    WK_WRITE
  } walk_state_t;
endpackage

// File: rtl/rop_regs.sv
module rop_regs
  import rop_blit_pkg::*;
#(
  parameter int AW  = 22,
  parameter int DW  = 12,
  parameter int PIX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [AW-1:0]     wdata,
  input  logic              busy,
  output logic [AW-1:0]     src_start,
  output logic [AW-1:0]     dst_start,
  output logic [DW-1:0]     src_pitch,
  output logic [DW-1:0]     dst_pitch,
  output logic [DW-1:0]     width_m1,
  output logic [DW-1:0]     height_m1,
  output logic [3:0]        rop,
  output logic              x_rev,
  output logic              y_rev,
  output logic              use_src,
  output logic [PIX-1:0]    colour,
  output logic              start
);
  logic acc;
  assign acc   = we && !busy;
  assign start = acc && (addr == RA_CTRL) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_start <= '0;
      dst_start <= '0;
      src_pitch <= '0;
      dst_pitch <= '0;
      width_m1  <= '0;
      height_m1 <= '0;
      rop       <= 4'h3;
      x_rev     <= 1'b0;
      y_rev     <= 1'b0;
      use_src   <= 1'b1;
      colour    <= '0;
    end else if (acc) begin
      unique case (addr)
        RA_SRC_START: src_start <= wdata;
        RA_DST_START: dst_start <= wdata;
        RA_SRC_PITCH: src_pitch <= wdata[DW-1:0];
        RA_DST_PITCH: dst_pitch <= wdata[DW-1:0];
        RA_WIDTH:     width_m1  <= wdata[DW-1:0];
        RA_HEIGHT:    height_m1 <= wdata[DW-1:0];
        RA_MODE: begin
          rop     <= wdata[3:0];
          x_rev   <= wdata[MB_XREV];
          y_rev   <= wdata[MB_YREV];
          use_src <= wdata[MB_SRC];
        end
        RA_COLOUR:    colour    <= wdata[PIX-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rop_mix.sv
module rop_mix #(
  parameter int PIX = 8
) (
  input  logic [3:0]     code,
  input  logic [PIX-1:0] s,
  input  logic [PIX-1:0] d,
  output logic [PIX-1:0] r
);
  always_comb begin
    unique case (code)
      4'h0: r = '0;
      4'h1: r = s & d;
      4'h2: r = s & ~d;
      4'h3: r = s;
      4'h4: r = ~s & d;
      4'h5: r = d;
      4'h6: r = s ^ d;
      4'h7: r = s | d;
      4'h8: r = ~(s | d);
      4'h9: r = ~(s ^ d);
      4'hA: r = ~d;
      4'hB: r = s | ~d;
      4'hC: r = ~s;
      4'hD: r = ~s | d;
      4'hE: r = ~(s & d);
      default: r = '1;
    endcase
  end
endmodule

// File: rtl/rop_walker.sv
module rop_walker
  import rop_blit_pkg::*;
#(
  parameter int AW  = 22,
  parameter int DW  = 12,
  parameter int PIX = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  src_start,
  input  logic [AW-1:0]  dst_start,
  input  logic [DW-1:0]  src_pitch,
  input  logic [DW-1:0]  dst_pitch,
  input  logic [DW-1:0]  width_m1,
  input  logic [DW-1:0]  height_m1,
  input  logic           x_rev,
  input  logic           y_rev,
  input  logic           use_src,
  input  logic [PIX-1:0] result,
  output logic [PIX-1:0] s_pix,
  output logic [PIX-1:0] d_pix,
  output logic           busy,
  output logic           done,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [PIX-1:0] mem_wdata,
  input  logic           mem_gnt,
  input  logic [PIX-1:0] mem_rdata
);
  walk_state_t st;
  logic [DW-1:0] x_cnt, y_cnt;
  logic [AW-1:0] src_row, dst_row, src_a, dst_a;
  logic [AW-1:0] x_step, s_ystep, d_ystep, src_row_n, dst_row_n;
  logic          last_px, row_end;
  walk_state_t   first_st;

  assign x_step    = x_rev ? {AW{1'b1}} : AW'(1);
  assign s_ystep   = y_rev ? (~AW'(src_pitch) + AW'(1)) : AW'(src_pitch);
  assign d_ystep   = y_rev ? (~AW'(dst_pitch) + AW'(1)) : AW'(dst_pitch);
  assign src_row_n = src_row + s_ystep;
  assign dst_row_n = dst_row + d_ystep;
  assign row_end   = (x_cnt == width_m1);
  assign last_px   = row_end && (y_cnt == height_m1);
  assign first_st  = use_src ? WK_SRC_REQ : WK_DST_REQ;

  assign busy      = (st != WK_IDLE);
  assign mem_req   = (st == WK_SRC_REQ) || (st == WK_DST_REQ) || (st == WK_WRITE);
  assign mem_we    = (st == WK_WRITE);
  assign mem_addr  = (st == WK_SRC_REQ) ? src_a : dst_a;
  assign mem_wdata = result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WK_IDLE;
      done    <= 1'b0;
      x_cnt   <= '0;
      y_cnt   <= '0;
      src_row <= '0;
      dst_row <= '0;
      src_a   <= '0;
      dst_a   <= '0;
      s_pix   <= '0;
      d_pix   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        WK_IDLE: if (start) begin
          x_cnt   <= '0;
          y_cnt   <= '0;
          src_row <= src_start;
          dst_row <= dst_start;
          src_a   <= src_start;
          dst_a   <= dst_start;
          st      <= first_st;
        end
        WK_SRC_REQ: if (mem_gnt) st <= WK_SRC_CAP;
        WK_SRC_CAP: begin
          s_pix <= mem_rdata;
          st    <= WK_DST_REQ;
        end
        WK_DST_REQ: if (mem_gnt) st <= WK_DST_CAP;
        WK_DST_CAP: begin
          d_pix <= mem_rdata;
          st    <= WK_WRITE;
        end
        WK_WRITE: if (mem_gnt) begin
          if (last_px) begin
            st   <= WK_IDLE;
            done <= 1'b1;
          end else begin
            st <= first_st;
            if (row_end) begin
              x_cnt   <= '0;
              y_cnt   <= y_cnt + DW'(1);
              src_row <= src_row_n;
              dst_row <= dst_row_n;
              src_a   <= src_row_n;
              dst_a   <= dst_row_n;
            end else begin
              x_cnt <= x_cnt + DW'(1);
              src_a <= src_a + x_step;
              dst_a <= dst_a + x_step;
            end
          end
        end
        default: st <= WK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rop_blit_engine.sv
module rop_blit_engine
  import rop_blit_pkg::*;
#(
  parameter int AW  = 22,
  parameter int DW  = 12,
  parameter int PIX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [PIX-1:0]    mem_wdata,
  input  logic              mem_gnt,
  input  logic [PIX-1:0]    mem_rdata
);
  logic [AW-1:0]  src_start, dst_start;
  logic [DW-1:0]  src_pitch, dst_pitch, width_m1, height_m1;
  logic [3:0]     rop;
  logic           x_rev, y_rev, use_src, start;
  logic [PIX-1:0] colour, s_pix, d_pix, s_oper, result;

  rop_regs #(.AW(AW), .DW(DW), .PIX(PIX)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .src_start(src_start), .dst_start(dst_start),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch), .width_m1(width_m1),
    .height_m1(height_m1), .rop(rop), .x_rev(x_rev), .y_rev(y_rev),
    .use_src(use_src), .colour(colour), .start(start)
  );

  assign s_oper = use_src ? s_pix : colour;

  rop_mix #(.PIX(PIX)) u_mix (
    .code(rop), .s(s_oper), .d(d_pix), .r(result)
  );

  rop_walker #(.AW(AW), .DW(DW), .PIX(PIX)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_start(src_start), .dst_start(dst_start),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .width_m1(width_m1), .height_m1(height_m1),
    .x_rev(x_rev), .y_rev(y_rev), .use_src(use_src), .result(result),
    .s_pix(s_pix), .d_pix(d_pix), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/rop_blit_checker.sv
module rop_blit_checker #(
  parameter int AW  = 22,
  parameter int PIX = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_we,
  input logic [3:0]     reg_addr,
  input logic [AW-1:0]  reg_wdata,
  input logic           busy,
  input logic           done,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [PIX-1:0] mem_wdata,
  input logic           mem_gnt
);
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R1

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd8 && reg_wdata[0] && !busy) |=> busy); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_gnt) |=> $stable(mem_wdata)); // R9

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(mem_req && mem_gnt && mem_we))); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind rop_blit_engine rop_blit_checker #(.AW(AW), .PIX(PIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_gnt(mem_gnt)
);

// File: tb/tb_rop_blit_engine.sv
`timescale 1ns/1ps
module tb_rop_blit_engine;
  localparam int MSZ = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [21:0] reg_wdata = '0;
  logic        busy, done, mem_req, mem_we, mem_gnt;
  logic [21:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #4 clk = ~clk;

  rop_blit_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [MSZ];
  logic [7:0] ref_mem [MSZ];
  logic [7:0] snap [MSZ];
  logic [7:0] lfsr = 8'hA5;
  int cyc = 0;
  int n_checks = 0, n_fail = 0;
  int wr_cnt, rd_cnt, last_wr_cyc, order_bad, done_cnt;
  int exp_addr [256];
  int exp_n;
  int last_rd_addr;

  assign mem_gnt = lfsr[0] | lfsr[3];

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (done) done_cnt <= done_cnt + 1;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[11:0]] <= mem_wdata;
        if (wr_cnt >= exp_n || exp_addr[wr_cnt] != int'(mem_addr[11:0])) order_bad <= order_bad + 1;
        if (last_rd_addr != int'(mem_addr[11:0])) order_bad <= order_bad + 1;
        wr_cnt      <= wr_cnt + 1;
        last_wr_cyc <= cyc;
      end else begin
        mem_rdata    <= mem[mem_addr[11:0]];
        rd_cnt       <= rd_cnt + 1;
        last_rd_addr <= int'(mem_addr[11:0]);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 22'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [7:0] mixf(input int code, input logic [7:0] s, input logic [7:0] d);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = code[{~s[b], ~d[b]}];
    return r;
  endfunction

  // reference walk; updates ref_mem in visit order
  task automatic model(input int sa0, input int da0, input int sp, input int dp,
                       input int w, input int h, input int code, input bit xr,
                       input bit yr, input bit us, input int fg);
    exp_n = 0;
    for (int y = 0; y <= h; y++)
      for (int x = 0; x <= w; x++) begin
        int sa = (sa0 + (yr ? -y*sp : y*sp) + (xr ? -x : x)) & (MSZ-1);
        int da = (da0 + (yr ? -y*dp : y*dp) + (xr ? -x : x)) & (MSZ-1);
        logic [7:0] s = us ? ref_mem[sa] : 8'(fg);
        ref_mem[da] = mixf(code, s, ref_mem[da]);
        exp_addr[exp_n] = da;
        exp_n++;
      end
  endtask

  task automatic wait_done(output int done_cyc);
    int guard = 0;
    done_cyc = -1;
    while (guard < 20000) begin
      @(negedge clk);
      if (done) begin done_cyc = cyc; break; end
      guard++;
    end
    check(done_cyc >= 0, "R10 watchdog", guard, 0);
  endtask

  task automatic run_blit(input int sa, input int da, input int sp, input int dp,
                          input int w, input int h, input int code, input bit xr,
                          input bit yr, input bit us, input int fg, input bit poke);
    int dc, mism;
    model(sa, da, sp, dp, w, h, code, xr, yr, us, fg);
    wr_reg(0, sa); wr_reg(1, da); wr_reg(2, sp); wr_reg(3, dp);
    wr_reg(4, w); wr_reg(5, h);
    wr_reg(6, code | (int'(xr) << 4) | (int'(yr) << 5) | (int'(us) << 6));
    wr_reg(7, fg);
    wr_cnt = 0; rd_cnt = 0; order_bad = 0; done_cnt = 0; last_rd_addr = -1;
    wr_reg(8, 1);
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      // R11 restart and R2 config change during the job
      wr_reg(8, 1);
      wr_reg(6, (code ^ 4'hF) | (int'(!xr) << 4));
      wr_reg(0, sa + 7);
    end
    wait_done(dc);
    check(!busy, "R10 busy low with done", int'(busy), 0);
    check(dc == last_wr_cyc + 1, "R10 done timing", dc, last_wr_cyc + 1);
    repeat (6) @(negedge clk);
    check(done_cnt == 1, "R11 single done", done_cnt, 1);
    check(wr_cnt == (w+1)*(h+1), "R3 write count", wr_cnt, (w+1)*(h+1));
    check(rd_cnt == (us ? 2 : 1)*(w+1)*(h+1), "R5 R8 read count", rd_cnt,
          (us ? 2 : 1)*(w+1)*(h+1));
    check(order_bad == 0, "R6 R7 R8 write order", order_bad, 0);
    mism = 0;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== ref_mem[i]) mism++;
    check(mism == 0, $sformatf("R4 memory image rop %0d", code), mism, 0);
  endtask

  initial begin
    int mism;
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = 8'(i*37 + 5 + (i >> 8));
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req, "R1 reset state",
          int'({busy, done, mem_req}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !mem_req, "R1 idle after reset", int'({busy, mem_req}), 0);

    // R4: every operation code, source operand from memory
    for (int c = 0; c < 16; c++)
      run_blit(100 + c*3, 600 + c*5, 20, 30, 3, 2, c, 0, 0, 1, 0, 0);

    // R5: fixed colour operand, no source reads
    run_blit(0, 1500, 0, 25, 4, 3, 3, 0, 0, 0, 8'h5A, 0);
    run_blit(0, 1500, 0, 25, 4, 3, 6, 0, 0, 0, 8'hC3, 0);

    // R6 R7: all four walking directions, 1x1, single row and single column
    run_blit(2000, 2500, 16, 20, 4, 3, 6, 0, 0, 1, 0, 0);
    run_blit(2004, 2504, 16, 20, 4, 3, 6, 1, 0, 1, 0, 0);
    run_blit(2048, 2560, 16, 20, 4, 3, 6, 0, 1, 1, 0, 0);
    run_blit(2052, 2564, 16, 20, 4, 3, 6, 1, 1, 1, 0, 0);
    run_blit(3000, 3100, 1, 1, 0, 0, 9, 0, 0, 1, 0, 0);
    run_blit(3000, 3200, 8, 8, 7, 0, 3, 0, 0, 1, 0, 0);
    run_blit(3000, 3300, 8, 8, 0, 5, 3, 0, 0, 1, 0, 0);

    // R12: horizontal overlap, destination right of source, walk right to left
    for (int i = 0; i < MSZ; i++) snap[i] = mem[i];
    run_blit(1000 + 5, 1002 + 5, 16, 16, 5, 3, 3, 1, 0, 1, 0, 0);
    mism = 0;
    for (int y = 0; y <= 3; y++)
      for (int x = 0; x <= 5; x++)
        if (mem[1002 + y*16 + x] !== snap[1000 + y*16 + x]) mism++;
    check(mism == 0, "R12 horizontal overlap copy", mism, 0);

    // R12: vertical overlap, destination one row below, walk bottom to top
    for (int i = 0; i < MSZ; i++) snap[i] = mem[i];
    run_blit(1200 + 3*16, 1216 + 3*16, 16, 16, 5, 3, 3, 0, 1, 1, 0, 0);
    mism = 0;
    for (int y = 0; y <= 3; y++)
      for (int x = 0; x <= 5; x++)
        if (mem[1216 + y*16 + x] !== snap[1200 + y*16 + x]) mism++;
    check(mism == 0, "R12 vertical overlap copy", mism, 0);

    // R11 R2: restart and register writes during a job are ignored
    run_blit(3500, 3700, 10, 10, 5, 4, 7, 0, 0, 1, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule